// File: doc/BRIEF.md
# Configuration Scan Chain with Nonvolatile Save and Restore

This block holds a device's volatile configuration word and the nonvolatile copy behind it. A test-access controller drives it with capture, shift and update strobes and with a decoded programming opcode. Under the write and read opcodes, a serial path of configuration bits plus a trailer of reserved read-only stages sits between the serial input and the serial output. Under every other opcode, that path is a single-stage bypass register.

A sequencer copies the volatile word into a register array that models the nonvolatile cells, and copies it back again. Each transfer holds a busy flag for a fixed, parameterised number of clock cycles. At power-up it performs a restore on its own. Save and restore start only when the power-down input is inactive and the PLL is enabled. While busy, any new programming opcode is dropped and the bypass register stays on the serial path.

Top module: `cfg_scan_nv`

## Requirements
- R1: During reset and directly after it, `busy` is 1 and `cfg` is all zeros.
- R2: After reset, `busy` stays high for exactly BOOT_CYC cycles. When it falls, `cfg` takes the nonvolatile contents (NV_INIT after reset) if `pd_n` is 1 at that moment, and otherwise stays at zero.
- R3: With write (`op_i`=1) current, 112 shifts load the chain with serial bit k entering at shift k. Configuration bit 0 goes first and 16 filler bits follow the 96 data bits. A following `upd_dr` pulse copies chain stages 0..95 into `cfg`.
- R4: With read (`op_i`=2) current, `cap_dr` loads {RSV_PAT, cfg} into the chain. `tdo` then shows `cfg[0]` first, and stages 96..111 show RSV_PAT starting from its bit 0. An `upd_dr` under read leaves `cfg` unchanged.
- R5: Under any other opcode (0, or 5..7), `cap_dr` clears the one-stage bypass register so that `tdo` is 0, and each shift passes `tdi` to `tdo` one cycle later.
- R6: Save (`op_i`=3) becoming current through `upd_ir` raises `busy` for exactly SAVE_CYC cycles. When `busy` falls, `cfg` has been copied into the nonvolatile array.
- R7: Restore (`op_i`=4) becoming current raises `busy` for exactly RESTORE_CYC cycles. When `busy` falls, `cfg` equals the nonvolatile array.
- R8: A save or restore request is dropped without raising `busy` when `pd_n` is 0, `pll_en_n` is 1, or `cfg[57]` is 1.
- R9: While `busy` is 1, programming opcodes (1..4) presented at `upd_ir` are ignored. The bypass register stays on the serial path, and `upd_dr` does not change `cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low power-up reset |
| cap_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| upd_dr | input | 1 | Update-DR strobe |
| upd_ir | input | 1 | Update-IR strobe; `op_i` becomes current |
| tdi | input | 1 | Serial data in |
| op_i | input | 3 | Decoded opcode: 0 other, 1 write, 2 read, 3 save, 4 restore |
| pd_n | input | 1 | Power-down pin, high = powered |
| pll_en_n | input | 1 | PLL enable pin, low = enabled |
| tdo | output | 1 | Serial bit toward the test data output |
| cfg | output | 96 | Volatile configuration word |
| busy | output | 1 | Save, restore or power-up transfer in progress |

## Verification
The bench builds the block with SAVE_CYC=35, RESTORE_CYC=20 and BOOT_CYC=12 in place of the default cycle counts. These short durations let it time every busy window to the exact cycle. They also leave room for a lockout attempt to be made and observed inside a single save. NV_INIT is a nonzero pattern with bit 57 clear, so the power-up restore is visible and a later restore is not blocked by the PLL gate. RSV_PAT is asymmetric, so a reversed or shifted trailer shows up in the readback.

// File: rtl/cfg_nv_pkg.sv
package cfg_nv_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WRITE = 3'd1,
        OP_READ  = 3'd2,
        OP_SAVE  = 3'd3,
        OP_REST  = 3'd4
    } prog_op_e;

    typedef enum logic [1:0] {
        JOB_BOOT = 2'd0,
        JOB_SAVE = 2'd1,
        JOB_REST = 2'd2
    } nv_job_e;
endpackage

// File: rtl/cfg_scan_path.sv
module cfg_scan_path #(
    parameter int          CFG_W   = 96,
    parameter int          RSV_W   = 16,
    parameter logic [15:0] RSV_PAT = 16'h0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic             shift,
    input  logic             prog_sel,
    input  logic             tdi,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             tdo,
    output logic [CFG_W-1:0] word_o
);
    localparam int CHAIN_W = CFG_W + RSV_W;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
        logic               byp;
    } path_t;

    path_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (prog_sel) begin
            if (cap)
                st_d.chain = {RSV_PAT[RSV_W-1:0], cfg_i};
            else if (shift)
                st_d.chain = {tdi, st_q.chain[CHAIN_W-1:1]};
        end else begin
            if (cap)
                st_d.byp = 1'b0;
            else if (shift)
                st_d.byp = tdi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign tdo    = prog_sel ? st_q.chain[0] : st_q.byp;
    assign word_o = st_q.chain[CFG_W-1:0];
endmodule

// File: rtl/cfg_nv_seq.sv
module cfg_nv_seq
    import cfg_nv_pkg::*;
#(
    parameter int               CFG_W       = 96,
    parameter int               SAVE_CYC    = 550900,
    parameter int               RESTORE_CYC = 12300,
    parameter int               BOOT_CYC    = 30000,
    parameter logic [CFG_W-1:0] NV_INIT     = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_save,
    input  logic             start_rest,
    input  logic             pd_n,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             busy_o,
    output logic             load_o,
    output logic [CFG_W-1:0] nv_o
);
    localparam int MAX_AB = (SAVE_CYC > RESTORE_CYC) ? SAVE_CYC : RESTORE_CYC;
    localparam int MAX_C  = (MAX_AB > BOOT_CYC) ? MAX_AB : BOOT_CYC;
    localparam int CW     = $clog2(MAX_C + 1);

    typedef struct packed {
        logic             busy;
        nv_job_e          job;
        logic [CW-1:0]    cnt;
        logic [CFG_W-1:0] nv;
    } seq_t;

    seq_t st_d, st_q;
    logic load_d;

    always_comb begin
        st_d   = st_q;
        load_d = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                case (st_q.job)
                    JOB_SAVE: st_d.nv = cfg_i;
                    JOB_REST: load_d  = 1'b1;
                    default:  load_d  = pd_n;
                endcase
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start_save) begin
            st_d.busy = 1'b1;
            st_d.job  = JOB_SAVE;
            st_d.cnt  = CW'(SAVE_CYC - 1);
        end else if (start_rest) begin
            st_d.busy = 1'b1;
            st_d.job  = JOB_REST;
            st_d.cnt  = CW'(RESTORE_CYC - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b1;
            st_q.job  <= JOB_BOOT;
            st_q.cnt  <= CW'(BOOT_CYC - 1);
            st_q.nv   <= NV_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign load_o = load_d;
    assign nv_o   = st_q.nv;
endmodule

// File: rtl/cfg_scan_nv.sv
module cfg_scan_nv
    import cfg_nv_pkg::*;
#(
    parameter int               CFG_W       = 96,
    parameter int               RSV_W       = 16,
    parameter logic [15:0]      RSV_PAT     = 16'h0000,
    parameter int               PLL_BIT     = 57,
    parameter int               SAVE_CYC    = 550900,
    parameter int               RESTORE_CYC = 12300,
    parameter int               BOOT_CYC    = 30000,
    parameter logic [CFG_W-1:0] NV_INIT     = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_dr,
    input  logic             shift_dr,
    input  logic             upd_dr,
    input  logic             upd_ir,
    input  logic             tdi,
    input  logic [2:0]       op_i,
    input  logic             pd_n,
    input  logic             pll_en_n,
    output logic             tdo,
    output logic [CFG_W-1:0] cfg,
    output logic             busy
);
    typedef struct packed {
        prog_op_e         op;
        logic [CFG_W-1:0] cfg;
    } top_t;

    top_t st_d, st_q;

    prog_op_e         op_in;
    logic             is_prog, gate_ok, start_save, start_rest;
    logic             prog_sel, rd_sel, nv_load;
    logic [CFG_W-1:0] chain_word, nv_word;

    always_comb begin
        op_in      = (op_i inside {3'd1, 3'd2, 3'd3, 3'd4}) ? prog_op_e'(op_i) : OP_NONE;
        is_prog    = (op_in != OP_NONE);
        gate_ok    = pd_n && !pll_en_n && !st_q.cfg[PLL_BIT];
        start_save = upd_ir && !busy && gate_ok && (op_in == OP_SAVE);
        start_rest = upd_ir && !busy && gate_ok && (op_in == OP_REST);
        prog_sel   = !busy && (st_q.op inside {OP_WRITE, OP_READ});
        rd_sel     = prog_sel && (st_q.op == OP_READ);

        st_d = st_q;
        if (upd_ir && !(is_prog && busy))
            st_d.op = op_in;
        if (nv_load)
            st_d.cfg = nv_word;
        else if (upd_dr && !busy && st_q.op == OP_WRITE)
            st_d.cfg = chain_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.op  <= OP_NONE;
            st_q.cfg <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    cfg_scan_path #(
        .CFG_W   (CFG_W),
        .RSV_W   (RSV_W),
        .RSV_PAT (RSV_PAT)
    ) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap_dr),
        .shift    (shift_dr),
        .prog_sel (prog_sel),
        .tdi      (tdi),
        .cfg_i    (st_q.cfg),
        .tdo      (tdo),
        .word_o   (chain_word)
    );

    cfg_nv_seq #(
        .CFG_W       (CFG_W),
        .SAVE_CYC    (SAVE_CYC),
        .RESTORE_CYC (RESTORE_CYC),
        .BOOT_CYC    (BOOT_CYC),
        .NV_INIT     (NV_INIT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_save (start_save),
        .start_rest (start_rest),
        .pd_n       (pd_n),
        .cfg_i      (st_q.cfg),
        .busy_o     (busy),
        .load_o     (nv_load),
        .nv_o       (nv_word)
    );

    assign cfg = st_q.cfg;
endmodule

// File: rtl/cfg_nv_chk.sv
module cfg_nv_chk #(
    parameter int CFG_W = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_dr,
    input logic             upd_ir,
    input logic             upd_dr,
    input logic             pd_n,
    input logic             tdo,
    input logic             busy,
    input logic             rd_sel,
    input logic [CFG_W-1:0] cfg
);
    // R9: the configuration word cannot move while a transfer is still running
    a_r9_cfg_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg));

    // R5: while busy the serial path is the bypass stage, cleared by capture
    a_r5_bypass_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cap_dr) |=> !tdo);

    // R4: the first bit out after a read capture is configuration bit 0
    a_r4_read_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && cap_dr && !upd_dr) |=> (tdo == $past(cfg[0])));

    // R8: busy only rises from an opcode update with power applied
    a_r8_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(upd_ir) && $past(pd_n)));

    // R8: a request in power-down never starts a transfer
    a_r8_pd_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_ir && !pd_n && !busy) |=> !busy);
endmodule

bind cfg_scan_nv cfg_nv_chk #(.CFG_W(CFG_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_dr (cap_dr),
    .upd_ir (upd_ir),
    .upd_dr (upd_dr),
    .pd_n   (pd_n),
    .tdo    (tdo),
    .busy   (busy),
    .rd_sel (rd_sel),
    .cfg    (cfg)
);

// File: tb/tb_cfg_scan_nv.sv
module tb_cfg_scan_nv;
    localparam int          CFG_W   = 96;
    localparam int          RSV_W   = 16;
    localparam int          CH_W    = CFG_W + RSV_W;
    localparam logic [15:0] RSV_PAT = 16'hC35A;
    localparam int          SAVE_C  = 35;
    localparam int          REST_C  = 20;
    localparam int          BOOT_C  = 12;
    localparam logic [CFG_W-1:0] NV0 = 96'h0123_4567_89AB_CDEF_0F1E_2D3C;

    localparam logic [CFG_W-1:0] VEC [4] = '{
        96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        96'h8000_0000_0000_0000_0000_0001,
        96'hA5A5_5A5A_1234_5678_9ABC_DEF0,
        96'h0F0F_F0F0_C3C3_3C3C_7E7E_8181
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cap_dr = 1'b0, shift_dr = 1'b0, upd_dr = 1'b0, upd_ir = 1'b0;
    logic             tdi = 1'b0;
    logic [2:0]       op_i = 3'd0;
    logic             pd_n = 1'b1, pll_en_n = 1'b0;
    logic             tdo, busy;
    logic [CFG_W-1:0] cfg;

    int n_chk = 0, n_bad = 0, busy_n = 0;

    always #2.5 clk = ~clk;
    always @(negedge clk) if (busy) busy_n++;

    cfg_scan_nv #(
        .CFG_W(CFG_W), .RSV_W(RSV_W), .RSV_PAT(RSV_PAT), .PLL_BIT(57),
        .SAVE_CYC(SAVE_C), .RESTORE_CYC(REST_C), .BOOT_CYC(BOOT_C), .NV_INIT(NV0)
    ) dut (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(string req, logic [CH_W-1:0] act, logic [CH_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic set_op(logic [2:0] op);
        op_i = op; upd_ir = 1'b1; tick(); upd_ir = 1'b0;
    endtask

    task automatic scan_write(logic [CFG_W-1:0] d);
        cap_dr = 1'b1; tick(); cap_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < CH_W; i++) begin
            tdi = (i < CFG_W) ? d[i] : 1'b0;
            tick();
        end
        shift_dr = 1'b0; tdi = 1'b0; upd_dr = 1'b1; tick(); upd_dr = 1'b0;
    endtask

    task automatic scan_read(output logic [CH_W-1:0] r);
        cap_dr = 1'b1; tick(); cap_dr = 1'b0; shift_dr = 1'b1;
        for (int i = 0; i < CH_W; i++) begin
            r[i] = tdo;
            tick();
        end
        shift_dr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) tick();
    endtask

    initial begin
        #(5.0 * 20000);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [CH_W-1:0]  rd;
        logic [CFG_W-1:0] v, saved;
        #1; tick(); tick();
        check("R1 busy in reset", CH_W'(busy), CH_W'(1));
        check("R1 cfg in reset", CH_W'(cfg), '0);
        rst_n = 1'b1; busy_n = 0;
        check("R1 busy after reset", CH_W'(busy), CH_W'(1));
        wait_idle();
        check("R2 boot window", CH_W'(busy_n), CH_W'(BOOT_C));
        check("R2 boot restore", CH_W'(cfg), CH_W'(NV0));

        set_op(3'd2);
        scan_read(rd);
        check("R4 read after boot", rd, {RSV_PAT, NV0});

        set_op(3'd0);
        cap_dr = 1'b1; tick(); cap_dr = 1'b0;
        check("R5 bypass capture", CH_W'(tdo), '0);
        shift_dr = 1'b1; tdi = 1'b1; tick();
        check("R5 bypass shift 1", CH_W'(tdo), CH_W'(1));
        tdi = 1'b0; tick(); shift_dr = 1'b0;
        check("R5 bypass shift 0", CH_W'(tdo), '0);
        set_op(3'd6);
        cap_dr = 1'b1; tick(); cap_dr = 1'b0; shift_dr = 1'b1; tdi = 1'b1; tick();
        shift_dr = 1'b0; tdi = 1'b0;
        check("R5 unused code bypass", CH_W'(tdo), CH_W'(1));

        for (int k = 0; k < 4; k++) begin
            v = VEC[k]; v[57] = 1'b0;
            set_op(3'd1);
            scan_write(v);
            check("R3 write commit", CH_W'(cfg), CH_W'(v));
            set_op(3'd2);
            scan_read(rd);
            check("R4 readback", rd, {RSV_PAT, v});
        end
        saved = cfg;
        upd_dr = 1'b1; tick(); upd_dr = 1'b0;
        check("R4 update under read", CH_W'(cfg), CH_W'(saved));

        busy_n = 0;
        set_op(3'd3);
        check("R6 save starts", CH_W'(busy), CH_W'(1));
        set_op(3'd1);
        cap_dr = 1'b1; tick(); cap_dr = 1'b0;
        check("R9 bypass while busy", CH_W'(tdo), '0);
        shift_dr = 1'b1; tdi = 1'b1; tick(); shift_dr = 1'b0; tdi = 1'b0;
        check("R9 bypass shift while busy", CH_W'(tdo), CH_W'(1));
        upd_dr = 1'b1; tick(); upd_dr = 1'b0;
        wait_idle();
        check("R6 save window", CH_W'(busy_n), CH_W'(SAVE_C));
        check("R9 cfg held through lockout", CH_W'(cfg), CH_W'(saved));

        v = VEC[0]; v[57] = 1'b0;
        set_op(3'd1);
        scan_write(v);
        check("R3 overwrite before restore", CH_W'(cfg), CH_W'(v));
        busy_n = 0;
        set_op(3'd4);
        wait_idle();
        check("R7 restore window", CH_W'(busy_n), CH_W'(REST_C));
        check("R7 R6 restored saved word", CH_W'(cfg), CH_W'(saved));

        pll_en_n = 1'b1;
        set_op(3'd3);
        check("R8 pll disabled drops save", CH_W'(busy), '0);
        pll_en_n = 1'b0; pd_n = 1'b0;
        set_op(3'd4);
        check("R8 power-down drops restore", CH_W'(busy), '0);
        pd_n = 1'b1;
        v = VEC[1]; v[57] = 1'b1;
        set_op(3'd1);
        scan_write(v);
        set_op(3'd4);
        check("R8 bit57 drops restore", CH_W'(busy), '0);
        tick(); tick();
        check("R8 cfg kept", CH_W'(cfg), CH_W'(v));

        pd_n = 1'b0; rst_n = 1'b0; tick(); rst_n = 1'b1;
        wait_idle();
        check("R2 boot in power-down", CH_W'(cfg), '0);
        pd_n = 1'b1; tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule